// File: doc/BRIEF.md
# Banked Scratchpad Warp Access Sequencer

This block accepts one warp-wide load or store aimed at a 32-bank on-chip scratchpad and turns it into a series of bank transactions, one per clock. Each request carries 32 lanes, an active mask, one byte address per lane and an access size of 4, 8 or 16 bytes. Each bank moves one 4-byte word per cycle, so at most 128 bytes move per cycle. The lanes are cut into groups whose size depends on the access size. The groups are issued in ascending order. A group whose lanes hit one bank at several rows is replayed over as many cycles as it needs.

Conflicts are judged only inside a group. Lanes in different groups never compete, because their groups go out in different cycles anyway. For stores, the block steers each 4-byte word of a lane's data to the bank that word lands on. When the request is finished, the block pulses `done` together with the number of bank cycles it used.

Top module: `warp_bank_sequencer`

## Requirements
- R1: A lane's word k (k counts from 0 up to words-per-lane minus 1) goes to bank (address bits [6:2] + k) modulo 32, at row address bits [15:7]. Address bits [1:0] are ignored, and addresses are expected to be aligned to the access size.
- R2: `req_size` selects the grouping. Code 0 (4 bytes) makes one group of 32 lanes. Code 1 (8 bytes) makes two groups of 16 lanes. Code 2 (16 bytes) makes four groups of 8 lanes (lanes 0-7, 8-15, 16-23, 24-31). Code 3 is treated as code 2.
- R3: Groups are issued in ascending order. The cycle cost of a group is the largest number of distinct rows that its active lanes touch on any single bank. The total cost of a request is the sum of its group costs, and it is at most 32.
- R4: Active lanes of one group that touch the same word of the same bank share a single bank access. The number of bank-enable pulses in a group equals the number of distinct (bank, row) pairs it touches.
- R5: A group with no active lane costs no cycle. A request with an all-zero mask finishes with a count of 0.
- R6: `req_ready` is high exactly when no request is in progress, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `done` is a one-cycle pulse that rises in the cycle after the last transaction (in the cycle after acceptance for an empty mask). `done_cycles` holds the total cost. `bank_en` is zero whenever no request is in progress.
- R7: On a store, `bank_we` equals `bank_en`. The data on a bank is bits [32k+31:32k] of the lane's 128-bit field in `req_wdata`. If several lanes write the same word in one transaction, the lowest-numbered lane's data is written. A load asserts no `bank_we`.
- R8: 16-byte accesses to contiguous addresses from n active lanes starting at lane 0 take ceil(n/8) cycles. A full warp of contiguous 4-byte accesses takes 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (0: 4 B, 1: 8 B, 2/3: 16 B) |
| req_mask | input | 32 | Active lane mask, bit i = lane i |
| req_addr | input | 512 | Byte address of lane i in bits [16i+15:16i] |
| req_wdata | input | 4096 | Store data of lane i in bits [128i+127:128i] |
| bank_en | output | 32 | Bank access enable, bit b = bank b |
| bank_we | output | 32 | Bank write enable |
| bank_row | output | 288 | Row of bank b in bits [9b+8:9b] |
| bank_wdata | output | 1024 | Write word of bank b in bits [32b+31:32b] |
| done | output | 1 | Request finished (one-cycle pulse) |
| done_cycles | output | 6 | Bank cycles used by the finished request |

## Verification
The embedded assertions check, on every cycle, several rules. Each busy cycle must serve at least one pending slot. No bank is enabled while the block is idle or offering `req_ready`. Write enables stay inside bank enables, and a load never writes. `done` never lasts two cycles, and the reported count never exceeds 32. The exact cycle cost of replayed groups, the skipping of empty groups, the sharing of broadcast words and which lane's data lands in each bank row depend on the whole request. Only the bench's scenarios show these, by comparing cycle counts, bank-pulse counts and a shadow of the scratchpad contents against its own model.

// File: rtl/warp_bank_pkg.sv
package warp_bank_pkg;

  typedef enum logic [1:0] {
    SZ_WORD   = 2'd0,
    SZ_DWORD  = 2'd1,
    SZ_QWORD  = 2'd2,
    SZ_QWORD2 = 2'd3
  } acc_size_e;

  // log2 of 4-byte words per lane; code 3 behaves like 16-byte accesses
  function automatic logic [1:0] size_shift(input logic [1:0] code);
    return (code == SZ_QWORD2) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/warp_bank_slotmap.sv
// Maps the NB slots of the current group (slot j = lane-in-group * words + word)
// to a bank, a row and a store word.
module warp_bank_slotmap #(
  parameter int NB = 32,
  parameter int AW = 16,
  parameter int WW = 32,
  localparam int BW = $clog2(NB),
  localparam int RW = AW - BW - 2,
  localparam int LW = 4 * WW
) (
  input  logic [1:0]      grp,
  input  logic [1:0]      wsh,
  input  logic [AW-1:0]   addr  [NB],
  input  logic [LW-1:0]   wdata [NB],
  output logic [BW-1:0]   sbank [NB],
  output logic [RW-1:0]   srow  [NB],
  output logic [WW-1:0]   sword [NB]
);

  for (genvar j = 0; j < NB; j++) begin : g_slot
    int lane;
    int k;
    logic [AW-1:0] a;
    always_comb begin
      lane     = ((int'(grp) << (BW - int'(wsh))) + (j >> wsh)) % NB;
      k        = j & ((1 << wsh) - 1);
      a        = addr[lane];
      sbank[j] = a[BW+1:2] + BW'(k);
      srow[j]  = a[AW-1:BW+2];
      sword[j] = wdata[lane][k*WW +: WW];
    end
  end

endmodule

// File: rtl/warp_bank_arbiter.sv
// One bank access per bank per cycle: the lowest pending slot on a bank picks
// the row; every pending slot on that bank and row is served with it.
module warp_bank_arbiter #(
  parameter int NB = 32,
  parameter int RW = 9,
  parameter int WW = 32,
  localparam int BW = $clog2(NB)
) (
  input  logic [NB-1:0]  pend,
  input  logic [BW-1:0]  sbank [NB],
  input  logic [RW-1:0]  srow  [NB],
  input  logic [WW-1:0]  sword [NB],
  output logic [NB-1:0]  served,
  output logic [NB-1:0]  ben,
  output logic [RW-1:0]  brow  [NB],
  output logic [WW-1:0]  bword [NB]
);

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      ben[b]   = 1'b0;
      brow[b]  = '0;
      bword[b] = '0;
    end
    for (int j = NB - 1; j >= 0; j--) begin
      if (pend[j]) begin
        ben[sbank[j]]   = 1'b1;
        brow[sbank[j]]  = srow[j];
        bword[sbank[j]] = sword[j];
      end
    end
  end

  always_comb begin
    for (int j = 0; j < NB; j++)
      served[j] = pend[j] && (srow[j] == brow[sbank[j]]);
  end

endmodule

// File: rtl/warp_bank_sequencer.sv
module warp_bank_sequencer
  import warp_bank_pkg::*;
#(
  parameter int NB = 32,
  parameter int AW = 16,
  parameter int WW = 32,
  localparam int BW = $clog2(NB),
  localparam int RW = AW - BW - 2,
  localparam int LW = 4 * WW,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [NB-1:0]    req_mask,
  input  logic [NB*AW-1:0] req_addr,
  input  logic [NB*LW-1:0] req_wdata,
  output logic [NB-1:0]    bank_en,
  output logic [NB-1:0]    bank_we,
  output logic [NB*RW-1:0] bank_row,
  output logic [NB*WW-1:0] bank_wdata,
  output logic             done,
  output logic [CW-1:0]    done_cycles
);

  // active slots of group g
  function automatic logic [NB-1:0] slot_active(input logic [NB-1:0] m,
                                                input logic [1:0] s,
                                                input logic [2:0] g);
    logic [NB-1:0] v;
    for (int j = 0; j < NB; j++)
      v[j] = m[((int'(g) << (BW - int'(s))) + (j >> s)) % NB];
    return v;
  endfunction

  // {found, index} of the lowest non-empty group at or above 'from'
  function automatic logic [2:0] first_group(input logic [NB-1:0] m,
                                             input logic [1:0] s,
                                             input logic [2:0] from);
    logic [2:0] r;
    r = '0;
    for (int g = 3; g >= 0; g--)
      if (g >= int'(from) && g < (1 << s) && slot_active(m, s, 3'(g)) != '0)
        r = {1'b1, 2'(g)};
    return r;
  endfunction

  logic            busy, wr;
  logic [1:0]      wsh, grp;
  logic [NB-1:0]   mask, pend;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   addr_q  [NB];
  logic [LW-1:0]   wdata_q [NB];

  logic [BW-1:0]   sbank [NB];
  logic [RW-1:0]   srow  [NB];
  logic [WW-1:0]   sword [NB];
  logic [NB-1:0]   served, ben;
  logic [RW-1:0]   brow  [NB];
  logic [WW-1:0]   bword [NB];

  // named events
  logic            accept;
  logic [1:0]      acc_sh;
  logic [2:0]      acc_first, nxt_first;
  logic [NB-1:0]   pend_left;
  logic            group_end;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign acc_sh    = size_shift(req_size);
  assign acc_first = first_group(req_mask, acc_sh, 3'd0);
  assign nxt_first = first_group(mask, wsh, {1'b0, grp} + 3'd1);
  assign pend_left = pend & ~served;
  assign group_end = busy && (pend_left == '0);

  warp_bank_slotmap #(.NB(NB), .AW(AW), .WW(WW)) slot_i (
    .grp(grp), .wsh(wsh), .addr(addr_q), .wdata(wdata_q),
    .sbank(sbank), .srow(srow), .sword(sword)
  );

  warp_bank_arbiter #(.NB(NB), .RW(RW), .WW(WW)) arb_i (
    .pend(pend), .sbank(sbank), .srow(srow), .sword(sword),
    .served(served), .ben(ben), .brow(brow), .bword(bword)
  );

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < NB; i++) begin
        addr_q[i]  <= req_addr[i*AW +: AW];
        wdata_q[i] <= req_wdata[i*LW +: LW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      wr          <= 1'b0;
      wsh         <= '0;
      grp         <= '0;
      mask        <= '0;
      pend        <= '0;
      cnt         <= '0;
      done        <= 1'b0;
      done_cycles <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        mask <= req_mask;
        wr   <= req_write;
        wsh  <= acc_sh;
        cnt  <= '0;
        if (acc_first[2]) begin
          busy <= 1'b1;
          grp  <= acc_first[1:0];
          pend <= slot_active(req_mask, acc_sh, acc_first);
        end else begin
          done        <= 1'b1;
          done_cycles <= '0;
        end
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (group_end) begin
          if (nxt_first[2]) begin
            grp  <= nxt_first[1:0];
            pend <= slot_active(mask, wsh, nxt_first);
          end else begin
            busy        <= 1'b0;
            pend        <= '0;
            done        <= 1'b1;
            done_cycles <= cnt + 1'b1;
          end
        end else begin
          pend <= pend_left;
        end
      end
    end
  end

  always_comb begin
    bank_en = ben;
    bank_we = ben & {NB{wr}};
    for (int b = 0; b < NB; b++) begin
      bank_row[b*RW +: RW]   = brow[b];
      bank_wdata[b*WW +: WW] = bword[b];
    end
  end

  // R3: every busy cycle serves at least one pending slot
  a_r3_progress: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (served != '0));
  // R3: reported cost is bounded by the slot count
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_cycles <= CW'(NB)));
  // R6: no bank activity while a new request may be taken
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bank_en == '0));
  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: a non-zero count follows a cycle of bank activity
  a_r6_done_after_txn: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_cycles != '0) |-> ($past(bank_en) != '0));
  // R7: write enables only on enabled banks
  a_r7_we_inside_en: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we & ~bank_en) == '0);
  // R7: loads never write
  a_r7_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr) |-> (bank_we == '0));

endmodule

// File: tb/warp_bank_sequencer_tb_top.sv
module warp_bank_sequencer_tb_top;

  localparam int NB = 32;
  localparam int AW = 16;
  localparam int RW = 9;
  localparam int NR = 512;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [1:0]        req_size = '0;
  logic [31:0]       req_mask = '0;
  logic [NB*16-1:0]  req_addr = '0;
  logic [NB*128-1:0] req_wdata = '0;
  logic [31:0]       bank_en, bank_we;
  logic [NB*RW-1:0]  bank_row;
  logic [NB*32-1:0]  bank_wdata;
  logic              done;
  logic [5:0]        done_cycles;

  always #2.5 clk = ~clk;

  warp_bank_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_mask(req_mask),
    .req_addr(req_addr), .req_wdata(req_wdata), .bank_en(bank_en),
    .bank_we(bank_we), .bank_row(bank_row), .bank_wdata(bank_wdata),
    .done(done), .done_cycles(done_cycles)
  );

  int checks = 0;
  int errors = 0;

  logic [15:0]  a_l [NB];
  logic [127:0] d_l [NB];
  logic [31:0]  mem  [NB][NR];
  logic [31:0]  emem [NB][NR];
  bit           tch  [NB][NR];

  int          pulses, writes;
  logic [31:0] en_or;
  logic [8:0]  row12;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // shadow scratchpad, filled from the bank ports
  always @(negedge clk) begin
    if (rst_n) begin
      for (int b = 0; b < NB; b++) begin
        if (bank_en[b]) begin
          pulses++;
          en_or[b] = 1'b1;
          if (b == 12) row12 = bank_row[12*RW +: RW];
          if (bank_we[b]) begin
            mem[b][bank_row[b*RW +: RW]] = bank_wdata[b*32 +: 32];
            writes++;
          end
        end
      end
    end
  end

  // reference model: cost, distinct bank accesses, expected store image
  function automatic void model(input bit wr, input int s, input logic [31:0] m,
                                output int cost, output int pairs);
    int gl;
    gl = NB / s;
    cost = 0;
    pairs = 0;
    for (int g = 0; g < s; g++) begin
      int per [NB];
      int mx;
      mx = 0;
      for (int b = 0; b < NB; b++) per[b] = 0;
      for (int i = 0; i < gl; i++) begin
        int ln;
        ln = g * gl + i;
        if (m[ln]) begin
          for (int k = 0; k < s; k++) begin
            int bk;
            bit dup;
            bk = (int'(a_l[ln][6:2]) + k) % NB;
            dup = 1'b0;
            for (int i2 = 0; i2 < i; i2++) begin
              int l2;
              l2 = g * gl + i2;
              if (m[l2])
                for (int k2 = 0; k2 < s; k2++)
                  if ((int'(a_l[l2][6:2]) + k2) % NB == bk && a_l[l2][15:7] == a_l[ln][15:7])
                    dup = 1'b1;
            end
            if (!dup) begin
              per[bk]++;
              pairs++;
            end
          end
        end
      end
      for (int b = 0; b < NB; b++) if (per[b] > mx) mx = per[b];
      cost += mx;
      if (wr)
        for (int i = gl - 1; i >= 0; i--) begin
          int ln;
          ln = g * gl + i;
          if (m[ln])
            for (int k = 0; k < s; k++) begin
              int bk;
              bk = (int'(a_l[ln][6:2]) + k) % NB;
              emem[bk][a_l[ln][15:7]] = d_l[ln][32*k +: 32];
              tch[bk][a_l[ln][15:7]] = 1'b1;
            end
        end
    end
  endfunction

  function automatic int words_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic run_req(input bit wr, input logic [1:0] sz, input logic [31:0] m,
                         input int lit, input string rq);
    int ec, ep, lat, bad;
    model(wr, words_of(sz), m, ec, ep);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    for (int i = 0; i < NB; i++) begin
      req_addr[i*16 +: 16]    = a_l[i];
      req_wdata[i*128 +: 128] = d_l[i];
    end
    req_write = wr;
    req_size  = sz;
    req_mask  = m;
    req_valid = 1'b1;
    pulses = 0;
    writes = 0;
    en_or  = '0;
    row12  = '0;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (ec > 0) chk(!req_ready, "R6", "ready while busy", req_ready, 0);
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(done && done_cycles == ec, "R3", "cycle count vs model", done_cycles, ec);
    if (lit >= 0) chk(done_cycles == lit, rq, "directed cycle count", done_cycles, lit);
    chk(lat == ec + 1, "R6", "done latency", lat, ec + 1);
    chk(pulses == ep, "R4", "bank access pulses", pulses, ep);
    if (wr) begin
      bad = 0;
      for (int b = 0; b < NB; b++)
        for (int r = 0; r < NR; r++)
          if (tch[b][r]) begin
            if (mem[b][r] !== emem[b][r]) bad++;
            tch[b][r] = 1'b0;
          end
      chk(bad == 0, "R7", "store image mismatches", bad, 0);
    end else begin
      chk(writes == 0, "R7", "writes during load", writes, 0);
    end
    @(negedge clk);
    chk(!done && bank_en == '0, "R6", "quiet after done", bank_en, 0);
  endtask

  task automatic fill_contig(input int stride);
    for (int i = 0; i < NB; i++) begin
      a_l[i] = 16'(i * stride);
      d_l[i] = {$urandom, $urandom, $urandom, $urandom};
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++) begin
        mem[b][r] = '0;
        emem[b][r] = '0;
        tch[b][r] = 1'b0;
      end
    repeat (3) @(negedge clk);
    chk(req_ready && !done && bank_en == '0, "R6", "reset state", {req_ready, done}, 2);
    rst_n = 1'b1;

    // R8: 20 contiguous 16-byte lanes -> 3 cycles; full warp -> 4
    fill_contig(16);
    run_req(1'b1, 2'd2, 32'h000F_FFFF, 3, "R8");
    run_req(1'b0, 2'd2, 32'hFFFF_FFFF, 4, "R8");
    // R8: contiguous 4-byte full warp -> 1 cycle
    fill_contig(4);
    run_req(1'b1, 2'd0, 32'hFFFF_FFFF, 1, "R8");
    // R2: 8-byte full warp in two groups -> 2; code 3 acts as 16 bytes
    fill_contig(8);
    run_req(1'b0, 2'd1, 32'hFFFF_FFFF, 2, "R2");
    fill_contig(16);
    run_req(1'b0, 2'd3, 32'h000F_FFFF, 3, "R2");
    // R4: every lane reads the same word -> 1 cycle, 1 pulse
    fill_contig(0);
    run_req(1'b0, 2'd0, 32'hFFFF_FFFF, 1, "R4");
    chk(pulses == 1, "R4", "broadcast pulses", pulses, 1);
    // R7: every lane stores the same word, lane 0 wins
    run_req(1'b1, 2'd0, 32'hFFFF_FFFF, 1, "R7");
    chk(mem[0][0] == d_l[0][31:0], "R7", "lowest lane wins", mem[0][0], d_l[0][31:0]);
    // R3: 32 lanes on bank 0, all different rows -> 32 cycles
    fill_contig(128);
    run_req(1'b0, 2'd0, 32'hFFFF_FFFF, 32, "R3");
    // R3: four 16-byte lanes of one group on bank 0, distinct rows -> 4
    fill_contig(128);
    run_req(1'b0, 2'd2, 32'h0000_000F, 4, "R3");
    // R3: one lane per group, same banks, distinct rows -> one cycle each
    for (int i = 0; i < NB; i++) a_l[i] = 16'((i / 8) * 128);
    run_req(1'b0, 2'd2, 32'h0101_0101, 4, "R3");
    // R5: empty mask, and only the last group active
    run_req(1'b0, 2'd2, 32'h0000_0000, 0, "R5");
    fill_contig(16);
    run_req(1'b0, 2'd2, 32'hFF00_0000, 1, "R5");
    // R1: one 16-byte lane at row 2, bank 12 -> banks 12..15 at row 2
    a_l[5] = {9'd2, 5'd12, 2'b00};
    run_req(1'b1, 2'd2, 32'h0000_0020, 1, "R1");
    chk(en_or == 32'h0000_F000, "R1", "bank set", en_or, 32'h0000_F000);
    chk(row12 == 9'd2, "R1", "row on bank 12", row12, 2);
    chk(mem[13][2] == d_l[5][63:32], "R1", "word 1 on bank 13", mem[13][2], d_l[5][63:32]);

    // constrained random mix
    for (int n = 0; n < 200; n++) begin
      logic [1:0]  sz;
      logic [31:0] m;
      int s;
      sz = 2'($urandom % 4);
      s = words_of(sz);
      case ($urandom % 4)
        0: m = 32'hFFFF_FFFF;
        1: m = 32'h1 << ($urandom % 32);
        default: m = $urandom;
      endcase
      for (int i = 0; i < NB; i++) begin
        int wb;
        wb = ($urandom % 32) & ~(s - 1);
        a_l[i] = {9'($urandom % 4), 5'(wb), 2'b00};
        d_l[i] = {$urandom, $urandom, $urandom, $urandom};
      end
      run_req(1'($urandom % 2), sz, m, -1, "R3");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R6 actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule